// File: doc/BRIEF.md
# Debug trap sequencer

This block sits beside the retirement stage of a simple in-order core and decides, one retired instruction at a time, whether a debug-related exception is raised. It tracks the single-step trap flag and handles the one-byte breakpoint opcode and the two-byte software interrupt. For the software interrupt it applies the I/O privilege check in protected and virtual-8086 modes.

Every output is combinational from the current retirement and a small amount of history. When a request is raised, the vector and the saved instruction pointer are valid in the same cycle. A software interrupt and a pending single-step can fall on the same retirement. In that case the interrupt is reported first and the single-step is deferred to the next retirement.

Top module: `dbg_trap_seq`

## Requirements
- R1: After reset, no single-step history remains. A retirement with `tf_i`=0 right after reset raises no request, even if the flag was set before reset. While reset is asserted and `retire_i` is 0, `exc_req_o` is 0.
- R2: A retirement with `tf_i`=1 raises no single-step request on that retirement. The next retirement raises `exc_req_o` with `exc_vec_o`=1.
- R3: The single-step decision for a retirement uses the flag value from the previous retirement. If the flag is cleared by retirement N, retirement N still traps and retirement N+1 does not.
- R4: A retirement with `is_bkpt_i`=1 (opcode 0xCC) raises vector 3 in every mode and at every privilege level, with `exc_ip_o`=`next_ip_i`.
- R5: A software interrupt (`is_swint_i`=1, operand `swint_vec_i`) in real mode (`mode_i`=2'b00) raises vector `swint_vec_i`, with no privilege check.
- R6: In protected mode (`mode_i`=2'b01, and 2'b11 is treated the same), a software interrupt raises `swint_vec_i` when `iopl_i` >= `cpl_i`. Otherwise it raises vector 13 with `exc_ip_o`=`cur_ip_i`.
- R7: In virtual-8086 mode (`mode_i`=2'b10), a software interrupt raises `swint_vec_i` only when `iopl_i`=3. Otherwise it raises vector 13 with `exc_ip_o`=`cur_ip_i`.
- R8: When a software interrupt or breakpoint retires while a single-step is pending, the interrupt vector is reported. The single-step (vector 1) is then reported on the next retirement, even if the flag is 0 by then.
- R9: `exc_req_o` is 1 only in cycles with `retire_i`=1. Cycles without retirement leave the single-step history unchanged.
- R10: Traps (vectors 1, 3, and a software interrupt that passes the check) report `exc_ip_o`=`next_ip_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | An instruction retires this cycle |
| tf_i | input | 1 | Single-step flag value after the retiring instruction |
| is_bkpt_i | input | 1 | Retiring instruction is the one-byte breakpoint |
| is_swint_i | input | 1 | Retiring instruction is the two-byte software interrupt |
| swint_vec_i | input | 8 | Operand of the software interrupt |
| mode_i | input | 2 | Operating mode: 00 real, 01 protected, 10 virtual-8086, 11 as protected |
| iopl_i | input | 2 | I/O privilege level |
| cpl_i | input | 2 | Current privilege level |
| cur_ip_i | input | 32 | Address of the retiring instruction |
| next_ip_i | input | 32 | Address of the next unexecuted instruction |
| exc_req_o | output | 1 | One-cycle exception request |
| exc_vec_o | output | 8 | Exception vector |
| exc_ip_o | output | 32 | Saved instruction pointer |

## Verification
The assertions assume two things about the inputs. First, the opcode class flags are meaningful only while `retire_i` is high. Second, `is_bkpt_i` and `is_swint_i` describe one decoded instruction, so the breakpoint flag wins if both are set. The stimulus drives the class flags only on retiring rows and never raises both flags on the same row. It changes inputs only on the falling edge, so the combinational outputs are sampled against settled state.

// File: rtl/dbg_trap_pkg.sv
package dbg_trap_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_PROT = 2'b01,
    MODE_V86  = 2'b10,
    MODE_RSVD = 2'b11
  } cpu_mode_e;

  localparam int unsigned VEC_W = 8;
  localparam logic [VEC_W-1:0] VEC_STEP = 8'd1;
  localparam logic [VEC_W-1:0] VEC_BKPT = 8'd3;
  localparam logic [VEC_W-1:0] VEC_GP   = 8'd13;
  localparam logic [1:0]       PL_USER  = 2'd3;
endpackage

// File: rtl/dbg_step_track.sv
module dbg_step_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic retire_i,
  input  logic tf_i,
  input  logic sw_hit_i,
  output logic step_due_o
);
  logic tf_q, hold_q;

  assign step_due_o = tf_q | hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tf_q   <= 1'b0;
      hold_q <= 1'b0;
    end else if (retire_i) begin
      tf_q   <= tf_i;
      // software interrupt wins; deferred step survives to next retirement
      hold_q <= sw_hit_i & step_due_o;
    end
  end

  p_step_after_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && tf_i) |=> step_due_o);

  p_hold_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_q) |-> $past(retire_i && sw_hit_i));

  p_idle_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_i |=> $stable(step_due_o));
endmodule

// File: rtl/dbg_swint_check.sv
module dbg_swint_check
  import dbg_trap_pkg::*;
(
  input  logic             is_bkpt_i,
  input  logic             is_swint_i,
  input  logic [VEC_W-1:0] swint_vec_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       iopl_i,
  input  logic [1:0]       cpl_i,
  output logic             sw_hit_o,
  output logic             gp_o,
  output logic [VEC_W-1:0] vec_o
);
  cpu_mode_e mode;
  logic      priv_ok;

  assign mode = cpu_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_REAL: priv_ok = 1'b1;
      MODE_V86:  priv_ok = (iopl_i == PL_USER);
      default:   priv_ok = (iopl_i >= cpl_i);
    endcase
  end

  assign sw_hit_o = is_bkpt_i | is_swint_i;
  // the one-byte breakpoint bypasses the privilege check
  assign gp_o     = is_swint_i & ~is_bkpt_i & ~priv_ok;

  always_comb begin
    if (is_bkpt_i)  vec_o = VEC_BKPT;
    else if (gp_o)  vec_o = VEC_GP;
    else            vec_o = swint_vec_i;
  end

  always_comb begin
    p_bkpt_no_gp_r4: assert (!(is_bkpt_i && gp_o));
  end
endmodule

// File: rtl/dbg_trap_seq.sv
module dbg_trap_seq
  import dbg_trap_pkg::*;
#(
  parameter int unsigned IP_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic             tf_i,
  input  logic             is_bkpt_i,
  input  logic             is_swint_i,
  input  logic [VEC_W-1:0] swint_vec_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       iopl_i,
  input  logic [1:0]       cpl_i,
  input  logic [IP_W-1:0]  cur_ip_i,
  input  logic [IP_W-1:0]  next_ip_i,
  output logic             exc_req_o,
  output logic [VEC_W-1:0] exc_vec_o,
  output logic [IP_W-1:0]  exc_ip_o
);
  logic             sw_hit, gp, step_due;
  logic [VEC_W-1:0] sw_vec;

  dbg_swint_check i_swint_check (
    .is_bkpt_i   (is_bkpt_i),
    .is_swint_i  (is_swint_i),
    .swint_vec_i (swint_vec_i),
    .mode_i      (mode_i),
    .iopl_i      (iopl_i),
    .cpl_i       (cpl_i),
    .sw_hit_o    (sw_hit),
    .gp_o        (gp),
    .vec_o       (sw_vec)
  );

  dbg_step_track i_step_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .retire_i   (retire_i),
    .tf_i       (tf_i),
    .sw_hit_i   (sw_hit),
    .step_due_o (step_due)
  );

  assign exc_req_o = retire_i & (sw_hit | step_due);
  assign exc_vec_o = sw_hit ? sw_vec : VEC_STEP;
  // a privilege fault reports the faulting instruction, traps the next one
  assign exc_ip_o  = gp ? cur_ip_i : next_ip_i;

  always_comb begin
    p_req_in_retire_r9: assert (!exc_req_o || retire_i);
  end

  p_bkpt_vec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && is_bkpt_i) |-> (exc_req_o && exc_vec_o == VEC_BKPT && exc_ip_o == next_ip_i));

  p_real_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && is_swint_i && !is_bkpt_i && mode_i == 2'b00) |-> (exc_vec_o == swint_vec_i));

  p_v86_gp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && is_swint_i && !is_bkpt_i && mode_i == 2'b10 && iopl_i != 2'd3)
      |-> (exc_req_o && exc_vec_o == VEC_GP && exc_ip_o == cur_ip_i));
endmodule

// File: tb/test_dbg_trap_seq.sv
`timescale 1ns/1ps
module test_dbg_trap_seq;
  typedef struct packed {
    logic       ret;
    logic       tf;
    logic       bkpt;
    logic       swi;
    logic [7:0] ivec;
    logic [1:0] mode;
    logic [1:0] iopl;
    logic [1:0] cpl;
    logic       ereq;
    logic [7:0] evec;
    logic       ecur;
    logic [3:0] req;
  } row_t;

  localparam int N = 24;
  localparam row_t TBL [N] = '{
    '{1'b1,1'b0,1'b0,1'b0,8'h00,2'd0,2'd0,2'd0,1'b0,8'd0, 1'b0,4'd2},  // 0  plain
    '{1'b1,1'b1,1'b0,1'b0,8'h00,2'd0,2'd0,2'd0,1'b0,8'd0, 1'b0,4'd2},  // 1  R2 setting instr
    '{1'b1,1'b1,1'b0,1'b0,8'h00,2'd0,2'd0,2'd0,1'b1,8'd1, 1'b0,4'd2},  // 2  R2 R10 step trap
    '{1'b0,1'b1,1'b0,1'b0,8'h00,2'd0,2'd0,2'd0,1'b0,8'd0, 1'b0,4'd9},  // 3  R9 no retire
    '{1'b1,1'b0,1'b0,1'b0,8'h00,2'd0,2'd0,2'd0,1'b1,8'd1, 1'b0,4'd3},  // 4  R3 cleared, still traps
    '{1'b1,1'b0,1'b0,1'b0,8'h00,2'd0,2'd0,2'd0,1'b0,8'd0, 1'b0,4'd3},  // 5  R3 quiet
    '{1'b1,1'b0,1'b1,1'b0,8'h00,2'd1,2'd0,2'd3,1'b1,8'd3, 1'b0,4'd4},  // 6  R4 prot low iopl
    '{1'b1,1'b0,1'b1,1'b0,8'h00,2'd2,2'd0,2'd3,1'b1,8'd3, 1'b0,4'd4},  // 7  R4 v86
    '{1'b1,1'b0,1'b0,1'b1,8'h21,2'd0,2'd0,2'd0,1'b1,8'h21,1'b0,4'd5},  // 8  R5 real
    '{1'b1,1'b0,1'b0,1'b1,8'h03,2'd1,2'd0,2'd3,1'b1,8'd13,1'b1,4'd6},  // 9  R6 fault
    '{1'b1,1'b0,1'b0,1'b1,8'h40,2'd1,2'd3,2'd3,1'b1,8'h40,1'b0,4'd6},  // 10 R6 pass
    '{1'b1,1'b0,1'b0,1'b1,8'h80,2'd3,2'd2,2'd2,1'b1,8'h80,1'b0,4'd6},  // 11 R6 equal, mode 11
    '{1'b1,1'b0,1'b0,1'b1,8'h03,2'd2,2'd2,2'd0,1'b1,8'd13,1'b1,4'd7},  // 12 R7 fault
    '{1'b1,1'b0,1'b0,1'b1,8'h30,2'd2,2'd3,2'd3,1'b1,8'h30,1'b0,4'd7},  // 13 R7 pass
    '{1'b1,1'b1,1'b0,1'b0,8'h00,2'd0,2'd0,2'd0,1'b0,8'd0, 1'b0,4'd8},  // 14 set flag
    '{1'b1,1'b0,1'b0,1'b1,8'h21,2'd0,2'd0,2'd0,1'b1,8'h21,1'b0,4'd8},  // 15 R8 clash
    '{1'b0,1'b0,1'b0,1'b0,8'h00,2'd0,2'd0,2'd0,1'b0,8'd0, 1'b0,4'd9},  // 16 R9 idle
    '{1'b1,1'b0,1'b0,1'b0,8'h00,2'd0,2'd0,2'd0,1'b1,8'd1, 1'b0,4'd8},  // 17 R8 deferred step
    '{1'b1,1'b0,1'b0,1'b0,8'h00,2'd0,2'd0,2'd0,1'b0,8'd0, 1'b0,4'd8},  // 18 R8 cleared
    '{1'b1,1'b1,1'b0,1'b0,8'h00,2'd0,2'd0,2'd0,1'b0,8'd0, 1'b0,4'd8},  // 19 set flag
    '{1'b1,1'b0,1'b1,1'b0,8'h00,2'd1,2'd0,2'd3,1'b1,8'd3, 1'b0,4'd8},  // 20 R8 bkpt clash
    '{1'b1,1'b0,1'b0,1'b1,8'h50,2'd0,2'd0,2'd0,1'b1,8'h50,1'b0,4'd8},  // 21 R8 second clash
    '{1'b1,1'b0,1'b0,1'b0,8'h00,2'd0,2'd0,2'd0,1'b1,8'd1, 1'b0,4'd8},  // 22 R8 deferred step
    '{1'b1,1'b0,1'b0,1'b0,8'h00,2'd0,2'd0,2'd0,1'b0,8'd0, 1'b0,4'd8}   // 23 quiet
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        retire_i = 1'b0, tf_i = 1'b0, is_bkpt_i = 1'b0, is_swint_i = 1'b0;
  logic [7:0]  swint_vec_i = '0;
  logic [1:0]  mode_i = '0, iopl_i = '0, cpl_i = '0;
  logic [31:0] cur_ip_i = '0, next_ip_i = '0;
  logic        exc_req_o;
  logic [7:0]  exc_vec_o;
  logic [31:0] exc_ip_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dbg_trap_seq i_dbg_trap_seq (
    .clk_i, .rst_ni, .retire_i, .tf_i, .is_bkpt_i, .is_swint_i, .swint_vec_i,
    .mode_i, .iopl_i, .cpl_i, .cur_ip_i, .next_ip_i, .exc_req_o, .exc_vec_o, .exc_ip_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input row_t r, input int k);
    retire_i = r.ret; tf_i = r.tf; is_bkpt_i = r.bkpt; is_swint_i = r.swi;
    swint_vec_i = r.ivec; mode_i = r.mode; iopl_i = r.iopl; cpl_i = r.cpl;
    next_ip_i = 32'h1000 + 32'(k) * 4;
    cur_ip_i  = 32'h1000 + 32'(k) * 4 - 2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    #1 chk("R1 req in reset", 32'(exc_req_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    for (int k = 0; k < N; k++) begin
      @(negedge clk_i);
      drive(TBL[k], k);
      #1;
      chk($sformatf("R%0d row %0d req", TBL[k].req, k), 32'(exc_req_o), 32'(TBL[k].ereq));
      if (TBL[k].ereq) begin
        chk($sformatf("R%0d row %0d vec", TBL[k].req, k), 32'(exc_vec_o), 32'(TBL[k].evec));
        chk($sformatf("R%0d row %0d ip", TBL[k].req, k), exc_ip_o,
            TBL[k].ecur ? cur_ip_i : next_ip_i); // R10 traps use next_ip
      end
    end
    // R1: flag set before reset leaves no trap afterwards
    @(negedge clk_i);
    drive(TBL[1], 40);
    @(negedge clk_i);
    retire_i = 1'b0; rst_ni = 1'b0;
    #1 chk("R1 req during reset", 32'(exc_req_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    drive(TBL[0], 41);
    #1 chk("R1 no step after reset", 32'(exc_req_o), 0);
    // R2: step trap follows one retirement later
    @(negedge clk_i) drive(TBL[1], 42);
    #1 chk("R2 setter quiet", 32'(exc_req_o), 0);
    @(negedge clk_i) drive(TBL[5], 43);
    #1 chk("R2 step req", 32'(exc_req_o), 1);
    chk("R2 step vec", 32'(exc_vec_o), 1);
    @(negedge clk_i) drive(TBL[5], 44);
    #1 chk("R3 step ends", 32'(exc_req_o), 0);
    @(negedge clk_i) retire_i = 1'b0;
    finish_run();
  end
endmodule